// File: doc/BRIEF.md
# Memory Region Address Firewall

This block sits on the request path in front of one protected memory range and returns a grant or block decision for each transaction. Each transaction carries an offset into the range, a read/write flag, a secure flag, a privilege flag and a 3-bit compartment ID. A small register file holds a fixed number of base regions. Each region has an enable, a secure attribute, an encryption request flag, an 8-bit privilege mask, inclusive start and end bounds, and separate 8-bit read and write masks that are indexed by compartment ID. The decision is combinational, so a bridge can use it in the same cycle it presents the request.

There are two independent request ports. Each port keeps a record of its first blocked transaction: the offset and the attributes of that access. A flag register reports which ports hold a record, and software clears a record by writing 1 to the matching bit of a clear register. A set-only lock bit freezes the region configuration. When the block is built with a single port, the second port never grants, and its record and flag read as zero.

Software programs the register file through a simple write-strobe interface. Reads are combinational. Region n, counted from 1, occupies the 64-byte window starting at 0x40·n.

Top module: `mrf_firewall`

## Requirements
- R1: Region n (1..NREG) places its config register at 0x40·n+0x0, its start register at +0x4, its end register at +0x8 and its compartment register at +0xC. The config register holds enable at bit 0, secure at bit 8, encryption request at bit 15 and the privilege mask at bits 23:16. The compartment register holds the read mask at bits 7:0 and the write mask at bits 23:16. Every field reads back as it was written.
- R2: The register at 0xFF0 reads back as {FW[7:0], LSB[7:0], 8'h00, NREG[7:0]}. Bits 31:24 give the compare width, bits 23:16 give log2 of the granularity, and bits 7:0 give the region count.
- R3: Start and end store only offset bits [LSB+FW-1:LSB], and all other bits read as 0. An offset hits a region when that bit field lies between start and end, both bounds inclusive.
- R4: A read by compartment c is granted in a region only when read-mask bit c is set. A write is granted only when write-mask bit c (register bit 16+c) is set.
- R5: A region whose secure bit is set blocks every non-secure transaction. A region whose secure bit is clear accepts both secure and non-secure transactions.
- R6: When privilege-mask bit c is set, a transaction from compartment c is granted only if its privilege flag is set.
- R7: A transaction that hits no enabled region is blocked. When several enabled regions overlap, the lowest-numbered region that hits decides.
- R8: A config write that sets bit 15 while bit 8 of the same write is clear stores the encryption bit as 0.
- R9: The first blocked transaction on a port is recorded. The port's status register (port 0 at 0x20, port 1 at 0x28) reads as write at bit 7, privilege at bit 5, secure at bit 4 and compartment at bits 2:0. The offset register (port 0 at 0x24, port 1 at 0x2C) reads the full offset. Later faults leave the record unchanged until it is cleared, and clearing zeroes it.
- R10: The flag register at 0x08 shows a general fault flag at bit 0, the port-0 flag at bit 1 and the port-1 flag at bit 2. Writing 1 to the same bit of the clear register at 0x0C clears that flag.
- R11: Port 1 makes its own grant decisions and keeps its own fault record, and a fault on port 1 does not touch the port-0 record.
- R12: Bit 0 of 0x00 is a lock that can only be set. While the lock is set, writes to region registers are ignored and the lock stays at 1, but clearing fault flags still works.
- R13: A grant output is never high while its valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| p0_valid | input | 1 | Port 0 transaction present |
| p0_addr | input | AW | Port 0 offset into the protected range |
| p0_write | input | 1 | Port 0 write (1) or read (0) |
| p0_secure | input | 1 | Port 0 secure transaction |
| p0_priv | input | 1 | Port 0 privileged transaction |
| p0_cid | input | 3 | Port 0 compartment ID |
| p0_grant | output | 1 | Port 0 access granted |
| p1_valid | input | 1 | Port 1 transaction present |
| p1_addr | input | AW | Port 1 offset into the protected range |
| p1_write | input | 1 | Port 1 write (1) or read (0) |
| p1_secure | input | 1 | Port 1 secure transaction |
| p1_priv | input | 1 | Port 1 privileged transaction |
| p1_cid | input | 3 | Port 1 compartment ID |
| p1_grant | output | 1 | Port 1 access granted |

## Verification
The bench builds the block with NREG=3, AW=16, LSB=4, FW=8 and DUAL_PORT=1. With these values the compare field is offset bits 11:4, and each region bound is a small 16-byte multiple. That makes it easy to probe the edges of an inclusive range one byte apart (0x1F, 0x20, 0x5F, 0x60), and it makes the masking of the start register visible in a single readback. Three regions are enough to build an overlap in which a lower-numbered region overrides a higher one. The second port is built in, so the bench can check that the two fault records stay independent.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
   localparam int NUM_CID = 8;
   localparam int CID_W   = 3;

   localparam logic [11:0] OFF_CTRL    = 12'h000;
   localparam logic [11:0] OFF_FLAGS   = 12'h008;
   localparam logic [11:0] OFF_CLEAR   = 12'h00C;
   localparam logic [11:0] OFF_P0_STAT = 12'h020;
   localparam logic [11:0] OFF_P0_ADDR = 12'h024;
   localparam logic [11:0] OFF_P1_STAT = 12'h028;
   localparam logic [11:0] OFF_P1_ADDR = 12'h02C;
   localparam logic [11:0] OFF_HWCFG   = 12'hFF0;

   localparam logic [5:0] SUB_CFG   = 6'h00;
   localparam logic [5:0] SUB_START = 6'h04;
   localparam logic [5:0] SUB_END   = 6'h08;
   localparam logic [5:0] SUB_CID   = 6'h0C;

   localparam int B_EN   = 0;
   localparam int B_SEC  = 8;
   localparam int B_ENC  = 15;
   localparam int B_PRIV = 16;
   localparam int B_RD   = 0;
   localparam int B_WR   = 16;

   function automatic logic [31:0] fault_word(input logic wr, input logic sec,
                                              input logic prv, input logic [CID_W-1:0] cid);
      return {24'h0, wr, 1'b0, prv, sec, 1'b0, cid};
   endfunction
endpackage

// File: rtl/mrf_region.sv
module mrf_region #(
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_cfg,
   input  logic          we_lo,
   input  logic          we_hi,
   input  logic          we_cid,
   input  logic          in_en,
   input  logic          in_sec,
   input  logic          in_enc,
   input  logic [7:0]    in_priv,
   input  logic [FW-1:0] in_bound,
   input  logic [7:0]    in_rd,
   input  logic [7:0]    in_wr,
   output logic          en,
   output logic          sec,
   output logic          enc,
   output logic [7:0]    priv,
   output logic [FW-1:0] lo,
   output logic [FW-1:0] hi,
   output logic [7:0]    rd_mask,
   output logic [7:0]    wr_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0; sec <= 1'b0; enc <= 1'b0; priv <= '0;
         lo <= '0; hi <= '0; rd_mask <= '0; wr_mask <= '0;
      end else begin
         if (we_cfg) begin
            en   <= in_en;
            sec  <= in_sec;
            enc  <= in_enc & in_sec;
            priv <= in_priv;
         end
         if (we_lo)  lo <= in_bound;
         if (we_hi)  hi <= in_bound;
         if (we_cid) begin
            rd_mask <= in_rd;
            wr_mask <= in_wr;
         end
      end
   end
endmodule

// File: rtl/mrf_port_check.sv
module mrf_port_check #(
   parameter int NREG = 4,
   parameter int AW   = 32,
   parameter int LSB  = 12,
   parameter int FW   = 20
) (
   input  logic [NREG-1:0]         en,
   input  logic [NREG-1:0]         sec,
   input  logic [NREG-1:0][7:0]    priv,
   input  logic [NREG-1:0][FW-1:0] lo,
   input  logic [NREG-1:0][FW-1:0] hi,
   input  logic [NREG-1:0][7:0]    rd_mask,
   input  logic [NREG-1:0][7:0]    wr_mask,
   input  logic                    valid,
   input  logic [AW-1:0]           addr,
   input  logic                    write,
   input  logic                    secure,
   input  logic                    privileged,
   input  logic [mrf_pkg::CID_W-1:0] cid,
   output logic                    grant
);
   logic [FW-1:0] field;
   logic          found;
   logic          ok;

   assign field = addr[LSB +: FW];

   always_comb begin
      found = 1'b0;
      ok    = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (!found && en[i] && field >= lo[i] && field <= hi[i]) begin
            found = 1'b1;
            ok = (!sec[i] || secure)
               && (!priv[i][cid] || privileged)
               && (write ? wr_mask[i][cid] : rd_mask[i][cid]);
         end
      end
   end

   assign grant = valid & ok;
endmodule

// File: rtl/mrf_fault_rec.sv
module mrf_fault_rec #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          grant,
   input  logic          write,
   input  logic          secure,
   input  logic          privileged,
   input  logic [mrf_pkg::CID_W-1:0] cid,
   input  logic [AW-1:0] addr,
   input  logic          clr,
   output logic          flag,
   output logic [31:0]   status,
   output logic [AW-1:0] fault_addr,
   output logic          capture
);
   assign capture = valid & ~grant & (~flag | clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0; status <= '0; fault_addr <= '0;
      end else begin
         if (clr) begin
            flag <= 1'b0; status <= '0; fault_addr <= '0;
         end
         if (capture) begin
            flag       <= 1'b1;
            status     <= mrf_pkg::fault_word(write, secure, privileged, cid);
            fault_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/mrf_firewall.sv
module mrf_firewall #(
   parameter int NREG      = 4,
   parameter int AW        = 32,
   parameter int LSB       = 12,
   parameter int FW        = 20,
   parameter bit DUAL_PORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [11:0]   reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          p0_valid,
   input  logic [AW-1:0] p0_addr,
   input  logic          p0_write,
   input  logic          p0_secure,
   input  logic          p0_priv,
   input  logic [2:0]    p0_cid,
   output logic          p0_grant,
   input  logic          p1_valid,
   input  logic [AW-1:0] p1_addr,
   input  logic          p1_write,
   input  logic          p1_secure,
   input  logic          p1_priv,
   input  logic [2:0]    p1_cid,
   output logic          p1_grant
);
   import mrf_pkg::*;

   localparam logic [31:0] HWCFG = {8'(FW), 8'(LSB), 8'h00, 8'(NREG)};

   if (NREG < 1 || NREG > 62) begin : g_bad_nreg
      $error("NREG out of range 1..62");
   end
   if (AW > 32 || LSB + FW > AW || FW < 1) begin : g_bad_width
      $error("compare field must fit in AW, AW at most 32");
   end

   logic                    lock_q, gflag_q;
   logic [2:0]              clr_bits;
   logic [NREG-1:0]         r_en, r_sec, r_enc;
   logic [NREG-1:0][7:0]    r_priv, r_rd, r_wr;
   logic [NREG-1:0][FW-1:0] r_lo, r_hi;
   logic                    flag0, flag1, cap0, cap1;
   logic [31:0]             stat0, stat1;
   logic [AW-1:0]           fault_addr0, fault_addr1;

   assign clr_bits = (reg_we && reg_addr == OFF_CLEAR) ? reg_wdata[2:0] : 3'b000;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic sel;
      assign sel = reg_we && !lock_q && reg_addr[11:6] == 6'(r + 1);
      mrf_region #(.FW(FW)) u_region (
         .clk(clk), .rst_n(rst_n),
         .we_cfg(sel && reg_addr[5:0] == SUB_CFG),
         .we_lo (sel && reg_addr[5:0] == SUB_START),
         .we_hi (sel && reg_addr[5:0] == SUB_END),
         .we_cid(sel && reg_addr[5:0] == SUB_CID),
         .in_en(reg_wdata[B_EN]), .in_sec(reg_wdata[B_SEC]), .in_enc(reg_wdata[B_ENC]),
         .in_priv(reg_wdata[B_PRIV +: 8]), .in_bound(reg_wdata[LSB +: FW]),
         .in_rd(reg_wdata[B_RD +: 8]), .in_wr(reg_wdata[B_WR +: 8]),
         .en(r_en[r]), .sec(r_sec[r]), .enc(r_enc[r]), .priv(r_priv[r]),
         .lo(r_lo[r]), .hi(r_hi[r]), .rd_mask(r_rd[r]), .wr_mask(r_wr[r])
      );
   end

   mrf_port_check #(.NREG(NREG), .AW(AW), .LSB(LSB), .FW(FW)) u_chk0 (
      .en(r_en), .sec(r_sec), .priv(r_priv), .lo(r_lo), .hi(r_hi),
      .rd_mask(r_rd), .wr_mask(r_wr),
      .valid(p0_valid), .addr(p0_addr), .write(p0_write), .secure(p0_secure),
      .privileged(p0_priv), .cid(p0_cid), .grant(p0_grant)
   );
   mrf_fault_rec #(.AW(AW)) u_rec0 (
      .clk(clk), .rst_n(rst_n), .valid(p0_valid), .grant(p0_grant),
      .write(p0_write), .secure(p0_secure), .privileged(p0_priv), .cid(p0_cid),
      .addr(p0_addr), .clr(clr_bits[1]),
      .flag(flag0), .status(stat0), .fault_addr(fault_addr0), .capture(cap0)
   );

   if (DUAL_PORT) begin : g_port1
      mrf_port_check #(.NREG(NREG), .AW(AW), .LSB(LSB), .FW(FW)) u_chk1 (
         .en(r_en), .sec(r_sec), .priv(r_priv), .lo(r_lo), .hi(r_hi),
         .rd_mask(r_rd), .wr_mask(r_wr),
         .valid(p1_valid), .addr(p1_addr), .write(p1_write), .secure(p1_secure),
         .privileged(p1_priv), .cid(p1_cid), .grant(p1_grant)
      );
      mrf_fault_rec #(.AW(AW)) u_rec1 (
         .clk(clk), .rst_n(rst_n), .valid(p1_valid), .grant(p1_grant),
         .write(p1_write), .secure(p1_secure), .privileged(p1_priv), .cid(p1_cid),
         .addr(p1_addr), .clr(clr_bits[2]),
         .flag(flag1), .status(stat1), .fault_addr(fault_addr1), .capture(cap1)
      );
   end else begin : g_single
      assign p1_grant    = 1'b0;
      assign flag1       = 1'b0;
      assign stat1       = '0;
      assign fault_addr1 = '0;
      assign cap1        = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         gflag_q <= 1'b0;
      end else begin
         if (reg_we && reg_addr == OFF_CTRL && reg_wdata[0]) lock_q <= 1'b1;
         if (clr_bits[0]) gflag_q <= 1'b0;
         if (cap0 || cap1) gflag_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_CTRL:    reg_rdata = {31'h0, lock_q};
         OFF_FLAGS:   reg_rdata = {29'h0, flag1, flag0, gflag_q};
         OFF_P0_STAT: reg_rdata = stat0;
         OFF_P0_ADDR: reg_rdata = 32'(fault_addr0);
         OFF_P1_STAT: reg_rdata = stat1;
         OFF_P1_ADDR: reg_rdata = 32'(fault_addr1);
         OFF_HWCFG:   reg_rdata = HWCFG;
         default: begin
            for (int r = 0; r < NREG; r++) begin
               if (reg_addr[11:6] == 6'(r + 1)) begin
                  case (reg_addr[5:0])
                     SUB_CFG: begin
                        reg_rdata[B_EN]         = r_en[r];
                        reg_rdata[B_SEC]        = r_sec[r];
                        reg_rdata[B_ENC]        = r_enc[r];
                        reg_rdata[B_PRIV +: 8]  = r_priv[r];
                     end
                     SUB_START: reg_rdata[LSB +: FW] = r_lo[r];
                     SUB_END:   reg_rdata[LSB +: FW] = r_hi[r];
                     SUB_CID: begin
                        reg_rdata[B_RD +: 8] = r_rd[r];
                        reg_rdata[B_WR +: 8] = r_wr[r];
                     end
                     default: reg_rdata = '0;
                  endcase
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/mrf_firewall_chk.sv
module mrf_firewall_chk #(
   parameter int NREG = 4,
   parameter int AW   = 32,
   parameter int FW   = 20
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    lock_q,
   input logic [NREG-1:0]         r_en,
   input logic [NREG-1:0]         r_sec,
   input logic [NREG-1:0]         r_enc,
   input logic [NREG-1:0][FW-1:0] r_lo,
   input logic [NREG-1:0][FW-1:0] r_hi,
   input logic                    p0_valid,
   input logic                    p0_grant,
   input logic                    p1_valid,
   input logic                    p1_grant,
   input logic                    flag0,
   input logic [2:0]              clr_bits,
   input logic [AW-1:0]           fault_addr0
);
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R12
   AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(r_en) && $stable(r_lo) && $stable(r_hi))); // R12
   AST_ENC_NEEDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      (r_enc & ~r_sec) == '0); // R8
   AST_GRANT0_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      p0_grant |-> p0_valid); // R13
   AST_GRANT1_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      p1_grant |-> p1_valid); // R13
   AST_FLAG_FROM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag0) |-> $past(p0_valid && !p0_grant)); // R9
   AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag0 && !clr_bits[1]) |=> $stable(fault_addr0)); // R9
endmodule

bind mrf_firewall mrf_firewall_chk #(.NREG(NREG), .AW(AW), .FW(FW)) u_assert (
   .clk(clk), .rst_n(rst_n), .lock_q(lock_q),
   .r_en(r_en), .r_sec(r_sec), .r_enc(r_enc), .r_lo(r_lo), .r_hi(r_hi),
   .p0_valid(p0_valid), .p0_grant(p0_grant), .p1_valid(p1_valid), .p1_grant(p1_grant),
   .flag0(flag0), .clr_bits(clr_bits), .fault_addr0(fault_addr0)
);

// File: tb/tb_mrf_firewall.sv
module tb_mrf_firewall;
   localparam int AW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic p0_valid = 0, p0_write = 0, p0_secure = 0, p0_priv = 0, p0_grant;
   logic p1_valid = 0, p1_write = 0, p1_secure = 0, p1_priv = 0, p1_grant;
   logic [AW-1:0] p0_addr = '0, p1_addr = '0;
   logic [2:0] p0_cid = '0, p1_cid = '0;
   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mrf_firewall #(.NREG(3), .AW(AW), .LSB(4), .FW(8), .DUAL_PORT(1'b1)) dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk); reg_addr = a; #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic acc(int port, logic [AW-1:0] a, bit w, bit s, bit p, logic [2:0] c,
                      bit exp, string tag);
      @(negedge clk);
      if (port == 0) begin
         p0_valid = 1; p0_addr = a; p0_write = w; p0_secure = s; p0_priv = p; p0_cid = c;
      end else begin
         p1_valid = 1; p1_addr = a; p1_write = w; p1_secure = s; p1_priv = p; p1_cid = c;
      end
      #1;
      chk(tag, 32'(port == 0 ? p0_grant : p1_grant), 32'(exp));
      @(negedge clk); p0_valid = 0; p1_valid = 0;
   endtask

   task automatic t_reset;
      rd(12'h000, 32'h0, "R12 lock clear at reset");
      rd(12'h008, 32'h0, "R10 flags clear at reset");
      rd(12'hFF0, 32'h0804_0003, "R2 hardware config");
      rd(12'h040, 32'h0, "R1 region config zero at reset");
      acc(0, 16'h0020, 0, 0, 0, 3'd1, 0, "R7 no region enabled");
   endtask

   task automatic t_basic;
      wr(12'h044, 32'h20); wr(12'h048, 32'h50);
      wr(12'h04C, 32'h0004_0006); wr(12'h040, 32'h1);
      rd(12'h040, 32'h1, "R1 config readback");
      rd(12'h04C, 32'h0004_0006, "R1 compartment readback");
      rd(12'h044, 32'h20, "R1 start readback");
      acc(0, 16'h0020, 0, 0, 0, 3'd1, 1, "R4 read cid1 allowed");
      acc(0, 16'h005F, 0, 0, 0, 3'd1, 1, "R3 last byte inside");
      acc(0, 16'h0060, 0, 0, 0, 3'd1, 0, "R3 first byte past end");
      acc(0, 16'h001F, 0, 0, 0, 3'd1, 0, "R3 byte before start");
      acc(0, 16'h0030, 1, 0, 0, 3'd1, 0, "R4 write cid1 denied");
      acc(0, 16'h0030, 1, 0, 0, 3'd2, 1, "R4 write cid2 allowed");
      acc(0, 16'h0030, 0, 0, 0, 3'd0, 0, "R4 read cid0 denied");
      @(negedge clk); p0_addr = 16'h0020; p0_cid = 3'd1; p0_write = 0; p0_valid = 0; #1;
      chk("R13 no grant without valid", 32'(p0_grant), 32'h0);
      wr(12'h0C4, 32'hFFFF_FFFF);
      rd(12'h0C4, 32'h0000_0FF0, "R3 start keeps only field bits");
   endtask

   task automatic t_secure;
      wr(12'h084, 32'h100); wr(12'h088, 32'h1F0);
      wr(12'h08C, 32'h00FF_00FF); wr(12'h080, 32'h0008_0101);
      rd(12'h080, 32'h0008_0101, "R1 secure config readback");
      acc(0, 16'h0100, 0, 0, 0, 3'd0, 0, "R5 non-secure blocked");
      acc(0, 16'h0100, 0, 1, 0, 3'd0, 1, "R5 secure granted");
      acc(0, 16'h0150, 0, 1, 0, 3'd3, 0, "R6 unprivileged cid3 blocked");
      acc(0, 16'h0150, 0, 1, 1, 3'd3, 1, "R6 privileged cid3 granted");
      acc(0, 16'h01FF, 1, 1, 0, 3'd4, 1, "R6 cid4 not privilege-gated");
   endtask

   task automatic t_enc;
      wr(12'h0C0, 32'h0000_8001);
      rd(12'h0C0, 32'h0000_0001, "R8 encryption dropped without secure");
      wr(12'h0C0, 32'h0000_8101);
      rd(12'h0C0, 32'h0000_8101, "R8 encryption kept with secure");
   endtask

   task automatic t_overlap;
      wr(12'h0C0, 32'h0); wr(12'h0C4, 32'h0); wr(12'h0C8, 32'hF0);
      wr(12'h0CC, 32'h0000_00FF); wr(12'h0C0, 32'h1);
      acc(0, 16'h0030, 0, 0, 0, 3'd0, 0, "R7 lower region wins overlap");
      acc(0, 16'h0030, 0, 0, 0, 3'd1, 1, "R7 lower region grants cid1");
      acc(0, 16'h0080, 0, 0, 0, 3'd0, 1, "R7 region3 alone grants");
      acc(0, 16'h0080, 1, 0, 0, 3'd0, 0, "R4 region3 write denied");
      acc(0, 16'h0200, 0, 1, 1, 3'd0, 0, "R7 unmapped offset blocked");
   endtask

   task automatic t_fault;
      wr(12'h00C, 32'h7);
      rd(12'h008, 32'h0, "R10 all flags cleared");
      acc(0, 16'h0044, 1, 0, 0, 3'd1, 0, "R9 fault stimulus");
      rd(12'h008, 32'h3, "R10 general and port0 flags");
      rd(12'h020, 32'h81, "R9 port0 status");
      rd(12'h024, 32'h44, "R9 port0 offset");
      acc(0, 16'h0200, 0, 1, 0, 3'd6, 0, "R9 second fault stimulus");
      rd(12'h024, 32'h44, "R9 first fault kept");
      rd(12'h020, 32'h81, "R9 first status kept");
      wr(12'h00C, 32'h2);
      rd(12'h008, 32'h1, "R10 port0 flag cleared only");
      rd(12'h024, 32'h0, "R9 record zeroed by clear");
      wr(12'h00C, 32'h1);
      rd(12'h008, 32'h0, "R10 general flag cleared");
   endtask

   task automatic t_port1;
      acc(1, 16'h0100, 0, 0, 0, 3'd5, 0, "R11 port1 non-secure blocked");
      rd(12'h008, 32'h5, "R11 general and port1 flags");
      rd(12'h028, 32'h05, "R11 port1 status");
      rd(12'h02C, 32'h100, "R11 port1 offset");
      rd(12'h020, 32'h0, "R11 port0 record untouched");
      acc(1, 16'h0100, 0, 1, 0, 3'd5, 1, "R11 port1 secure granted");
      wr(12'h00C, 32'h7);
      rd(12'h008, 32'h0, "R10 clear both ports");
   endtask

   task automatic t_lock;
      wr(12'h000, 32'h1);
      rd(12'h000, 32'h1, "R12 lock set");
      wr(12'h040, 32'h0);
      rd(12'h040, 32'h1, "R12 config write ignored");
      acc(0, 16'h0020, 0, 0, 0, 3'd1, 1, "R12 region still active");
      wr(12'h048, 32'h10);
      rd(12'h048, 32'h50, "R12 end write ignored");
      wr(12'h000, 32'h0);
      rd(12'h000, 32'h1, "R12 lock cannot clear");
      acc(0, 16'h0300, 0, 0, 0, 3'd0, 0, "R12 fault under lock");
      rd(12'h008, 32'h3, "R12 fault captured under lock");
      wr(12'h00C, 32'h3);
      rd(12'h008, 32'h0, "R12 clear works under lock");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset(); t_basic(); t_secure(); t_enc();
      t_overlap(); t_fault(); t_port1(); t_lock();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule